// File: doc/BRIEF.md
# Word-Striped Lane Gatherer

This block rebuilds a stream of 32-bit words that arrives spread over four byte-wide lanes. Each word travels whole on a single lane, one byte per clock, least significant byte first. Consecutive words of the stream use lanes 0, 1, 2, 3 and then lane 0 again, and each lane starts its word one clock after the lane before it. The gatherer collects each lane's bytes into a word register of that lane. A word becomes available only after its last byte has been captured. A rotation pointer then drains the lanes in turn, one lane per clock, so that a staggered stream comes out as one 32-bit word per clock in its original order.

Each lane is run by a small state machine with two states. `LN_IDLE` means no partial word is held. `LN_GATHER` means a word is partly collected. A valid byte with the start marker moves a lane from `LN_IDLE` to `LN_GATHER`; this is the *open* transition. A valid byte without the marker keeps the lane in `LN_GATHER`; this is the *append* transition. A valid byte with the marker while in `LN_GATHER` begins a new word at slot 0; this is the *restart* transition. The fourth byte sends the lane back to `LN_IDLE`; this is the *complete* transition. A completed word waits in a per-lane hold register until the pointer reaches that lane.

Top module: `stripe_gather`

## Requirements
- R1: On lane L, i_lane_data[8L+7:8L] carries the byte. A valid byte with i_lane_sow[L]=1 goes to word bits [7:0]. The next three valid bytes on that lane go to bits [15:8], [23:16] and [31:24], in that order.
- R2: A valid byte without a start marker on a lane that holds no partial word is discarded and never reaches o_word.
- R3: A start marker that arrives part-way through a word discards the partial word. That byte becomes byte 0 of a new word.
- R4: A word is complete once its fourth byte is captured. It is held in its lane until the rotation pointer reaches that lane. Under the staggered traffic of R7 a held word is always drained before the same lane completes its next word.
- R5: The rotation pointer is 0 in the first clock after reset and advances by one lane every clock (0, 1, 2, 3, 0, ...), whether or not a word is taken.
- R6: The pointer selects lane p in cycle c. If lane p holds a completed word in cycle c, o_vld is high in cycle c+1 for exactly that clock and o_word carries the word. Otherwise o_vld is low in cycle c+1. A word whose last byte is presented in cycle a is therefore output in cycle c+1, where c is the first cycle at or after a+1 in which the pointer selects its lane.
- R7: For a stream whose word k travels on lane k mod 4 and starts no earlier than one clock after word k-1, the words leave on o_word in stream order with their values unchanged. Idle gaps may be inserted between words.
- R8: Reset clears all byte counters, lane registers and hold flags, sets the pointer to lane 0, and drives o_vld and o_word to 0. A partial word from before reset never completes afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_lane_data | input | 32 | Byte of lane L at bits [8L+7:8L] |
| i_lane_vld | input | 4 | Bit L: lane L presents a byte this clock |
| i_lane_sow | input | 4 | Bit L: the byte on lane L is the first byte of a word |
| o_word | output | 32 | Rebuilt word, meaningful while o_vld is high |
| o_vld | output | 1 | One-clock strobe for each released word |

## Verification
A byte presented in cycle n is captured at the edge that ends cycle n. The hold flag of its lane is therefore visible in cycle n+1. A word is taken in the first cycle c after that in which the pointer selects its lane, and it appears on o_vld/o_word in cycle c+1. The bench counts edges since reset to know the pointer position. For every word it computes the exact cycle in which the word is due, using its own function of the last-byte cycle and the lane number. It drives inputs and samples outputs on the falling edge. Each output strobe is compared with the next expected word for both value and cycle, and any missing or extra strobe is reported in the cycle where it occurs. The reset case waits eight clocks after a markerless byte before it judges that no word was produced.

// File: rtl/stripe_gather_pkg.sv
package stripe_gather_pkg;

    // Per-lane assembly state: no partial word held, or a word partly collected
    typedef enum logic [0:0] {
        LN_IDLE   = 1'b0,
        LN_GATHER = 1'b1
    } lane_state_e;

endpackage

// File: rtl/lane_assembler.sv
module lane_assembler
    import stripe_gather_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SLOTS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     i_vld,
    input  logic                     i_sow,
    input  logic [BYTE_W-1:0]        i_byte,
    input  logic                     i_take,
    output logic [BYTE_W*SLOTS-1:0]  o_word,
    output logic                     o_full,
    output logic                     o_done
);

    localparam int WORD_W = BYTE_W * SLOTS;
    localparam int CNT_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS - 1);

    lane_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [WORD_W-1:0]  acc_q, acc_d;
    logic [WORD_W-1:0]  hold_q;
    logic               full_q;
    logic [CNT_W-1:0]   slot;
    logic               grab;
    logic               done;

    // A start marker always targets slot 0; otherwise the running count
    assign slot = i_sow ? '0 : cnt_q;

    always_comb begin
        grab = 1'b0;
        unique case (state_q)
            LN_IDLE:   grab = i_vld && i_sow;   // open
            LN_GATHER: grab = i_vld;            // append or restart
        endcase
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        acc_d   = acc_q;
        done    = 1'b0;
        if (grab) begin
            acc_d[int'(slot)*BYTE_W +: BYTE_W] = i_byte;
            if (slot == LAST_SLOT) begin
                done    = 1'b1;                 // complete
                state_d = LN_IDLE;
                cnt_d   = '0;
            end else begin
                state_d = LN_GATHER;
                cnt_d   = slot + CNT_W'(1);
            end
        end
    end

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            acc_q   <= acc_d;
        end
    end

    // Output process: completed word waits here until the arbiter takes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else if (done) begin
            hold_q <= acc_d;
            full_q <= 1'b1;
        end else if (i_take) begin
            full_q <= 1'b0;
        end
    end

    assign o_word = hold_q;
    assign o_full = full_q;
    assign o_done = done;

endmodule

// File: rtl/rotation_arbiter.sv
module rotation_arbiter #(
    parameter int LANES  = 4,
    parameter int WORD_W = 32,
    parameter int PTR_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        i_full,
    input  logic [LANES*WORD_W-1:0] i_words,
    output logic [LANES-1:0]        o_take,
    output logic [PTR_W-1:0]        o_ptr,
    output logic [WORD_W-1:0]       o_word,
    output logic                    o_vld
);

    localparam logic [PTR_W-1:0] LAST_LANE = PTR_W'(LANES - 1);

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             hit;

    assign hit    = i_full[ptr_q];
    assign o_take = hit ? (LANES'(1) << ptr_q) : '0;
    assign ptr_d  = (ptr_q == LAST_LANE) ? '0 : ptr_q + PTR_W'(1);

    // Pointer register: moves every clock, taken or not
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // Output register: one strobe per drained word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_vld  <= 1'b0;
            o_word <= '0;
        end else begin
            o_vld <= hit;
            if (hit) o_word <= i_words[int'(ptr_q)*WORD_W +: WORD_W];
        end
    end

    assign o_ptr = ptr_q;

endmodule

// File: rtl/stripe_gather.sv
module stripe_gather #(
    parameter int LANES      = 4,
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES*BYTE_W-1:0]  i_lane_data,
    input  logic [LANES-1:0]         i_lane_vld,
    input  logic [LANES-1:0]         i_lane_sow,
    output logic [BYTE_W*WORD_BYTES-1:0] o_word,
    output logic                     o_vld
);

    localparam int WORD_W = BYTE_W * WORD_BYTES;
    localparam int PTR_W  = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES-1:0]        full_vec;
    logic [LANES-1:0]        done_vec;
    logic [LANES-1:0]        take_vec;
    logic [LANES*WORD_W-1:0] lane_words;
    logic [PTR_W-1:0]        lane_ptr;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_assembler #(
            .BYTE_W (BYTE_W),
            .SLOTS  (WORD_BYTES)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .i_vld  (i_lane_vld[g]),
            .i_sow  (i_lane_sow[g]),
            .i_byte (i_lane_data[g*BYTE_W +: BYTE_W]),
            .i_take (take_vec[g]),
            .o_word (lane_words[g*WORD_W +: WORD_W]),
            .o_full (full_vec[g]),
            .o_done (done_vec[g])
        );
    end

    rotation_arbiter #(
        .LANES  (LANES),
        .WORD_W (WORD_W),
        .PTR_W  (PTR_W)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .i_full  (full_vec),
        .i_words (lane_words),
        .o_take  (take_vec),
        .o_ptr   (lane_ptr),
        .o_word  (o_word),
        .o_vld   (o_vld)
    );

endmodule

// File: rtl/stripe_gather_chk.sv
module stripe_gather_chk #(
    parameter int LANES = 4,
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             o_vld,
    input logic [PTR_W-1:0] ptr,
    input logic [LANES-1:0] full_vec,
    input logic [LANES-1:0] done_vec,
    input logic [LANES-1:0] take_vec
);

    localparam logic [PTR_W-1:0] LAST_LANE = PTR_W'(LANES - 1);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!o_vld && ptr == '0)); // R8

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (ptr == (($past(ptr) == LAST_LANE) ? '0 : $past(ptr) + PTR_W'(1)))); // R5

    AST_VLD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && full_vec[ptr]) |=> o_vld); // R6

    AST_IDLE_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !full_vec[ptr]) |=> !o_vld); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((full_vec & done_vec & ~take_vec) == '0)); // R4

    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_vec) && ((take_vec & ~full_vec) == '0)); // R6

endmodule

bind stripe_gather stripe_gather_chk #(
    .LANES (LANES),
    .PTR_W (PTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .o_vld    (o_vld),
    .ptr      (lane_ptr),
    .full_vec (full_vec),
    .done_vec (done_vec),
    .take_vec (take_vec)
);

// File: tb/test_stripe_gather.sv
module test_stripe_gather;

    localparam int NW = 240;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lane_data;
    logic [3:0]  lane_vld;
    logic [3:0]  lane_sow;
    logic [31:0] o_word;
    logic        o_vld;

    int checks = 0;
    int errors = 0;
    int n;
    bit finished = 1'b0;

    logic [31:0] wv [NW];
    int          ts [NW];
    int          pre[NW];
    int          due[NW];

    always #4 clk = ~clk;   // 125 MHz

    stripe_gather i_stripe_gather (
        .clk         (clk),
        .rst_n       (rst_n),
        .i_lane_data (lane_data),
        .i_lane_vld  (lane_vld),
        .i_lane_sow  (lane_sow),
        .o_word      (o_word),
        .o_vld       (o_vld)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, n);
        end
    endtask

    // R6: last byte in cycle a on lane L -> taken in first c >= a+1 with c%4==L, out in c+1
    function automatic int due_cycle(input int last_cyc, input int lane);
        int c = last_cyc + 1;
        while ((c % 4) != lane) c++;
        return c + 1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic idle_inputs();
        lane_vld  = '0;
        lane_sow  = '0;
        lane_data = $urandom;
    endtask

    // Drive all lanes for cycle cyc from the schedule (R1, R2, R3)
    task automatic drive_cycle(input int cyc);
        lane_data = $urandom;
        lane_vld  = '0;
        lane_sow  = '0;
        for (int l = 0; l < 4; l++) begin
            bit busy = 1'b0;
            for (int k = l; k < NW; k += 4) begin
                if (cyc >= ts[k] - pre[k] && cyc < ts[k]) begin
                    busy = 1'b1;
                    lane_vld[l] = 1'b1;
                    lane_sow[l] = (cyc == ts[k] - pre[k]);
                end else if (cyc >= ts[k] && cyc <= ts[k] + 3) begin
                    busy = 1'b1;
                    lane_vld[l] = 1'b1;
                    lane_sow[l] = (cyc == ts[k]);
                    lane_data[l*8 +: 8] = wv[k][(cyc - ts[k])*8 +: 8];
                end
            end
            if (!busy && ($urandom % 5 == 0)) lane_vld[l] = 1'b1;   // R2 noise
        end
    endtask

    initial begin
        int idx;
        void'($urandom(32'd7341));
        rst_n = 1'b0;
        idle_inputs();

        // Schedule: directed words first, then random
        for (int k = 0; k < NW; k++) begin
            int gap = 0;
            wv[k]  = $urandom;
            pre[k] = 0;
            if (k >= 8 && ($urandom % 6 == 0)) pre[k] = 1 + ($urandom % 3);
            if (k >= 8 && ($urandom % 4 == 0)) gap = $urandom % 6;
            if (k == 0) ts[k] = 3;
            else        ts[k] = ts[k-1] + 1 + gap;
            if (k >= 4) ts[k] = max2(ts[k], ts[k-4] + 4 + pre[k]);
            else        ts[k] = max2(ts[k], pre[k] + 1);
        end
        wv[0] = 32'h03020100; wv[1] = 32'h13121110;
        wv[2] = 32'hFFFFFFFF; wv[3] = 32'h00000000;
        pre[4] = 2; ts[4] = max2(ts[3] + 1, ts[0] + 6);   // R3 restart after two bytes
        pre[5] = 3; ts[5] = max2(ts[4] + 1, ts[1] + 7);   // R3 restart after three bytes
        for (int k = 6; k < NW; k++) begin
            ts[k] = max2(ts[k], ts[k-1] + 1);
            if (k >= 4) ts[k] = max2(ts[k], ts[k-4] + 4 + pre[k]);
        end
        for (int k = 0; k < NW; k++) due[k] = due_cycle(ts[k] + 3, k % 4);

        // Reset state (R8)
        repeat (2) @(negedge clk);
        chk(o_vld == 1'b0, "R8 o_vld in reset", 32'(o_vld), 32'h0);
        chk(o_word == '0,  "R8 o_word in reset", o_word, 32'h0);

        // Reset mid-word: lane 0 holds three bytes, then reset, then a markerless byte
        rst_n = 1'b1;
        for (int b = 0; b < 3; b++) begin
            @(negedge clk);
            lane_vld = 4'b0001; lane_sow = (b == 0) ? 4'b0001 : 4'b0000;
            lane_data = 32'hA5A5A5A5;
        end
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        chk(o_vld == 1'b0 && o_word == '0, "R8 reset clears output", o_word, 32'h0);
        rst_n = 1'b1;
        lane_vld = 4'b0001; lane_sow = 4'b0000; lane_data = 32'h5A5A5A5A;
        @(negedge clk);
        idle_inputs();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(o_vld == 1'b0, "R8 R2 no word from pre-reset partial", 32'(o_vld), 32'h0);
        end

        // Main stream, counted from a fresh reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        idx = 0;
        drive_cycle(0);
        while (n <= due[NW-1] + 6) begin
            @(negedge clk);
            if (o_vld) begin
                if (idx < NW) begin
                    chk(o_word == wv[idx], "R1 R3 R7 word value/order", o_word, wv[idx]);
                    chk(n == due[idx], "R4 R5 R6 word timing", 32'(n), 32'(due[idx]));
                    idx++;
                end else begin
                    chk(1'b0, "R6 extra strobe", 32'(o_vld), 32'h0);
                end
            end else if (idx < NW && n == due[idx]) begin
                chk(1'b0, "R6 missing strobe", 32'(o_vld), 32'h1);
                idx++;
            end
            drive_cycle(n);
        end
        chk(idx == NW, "R7 all words delivered", 32'(idx), 32'(NW));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule